// File: doc/BRIEF.md
# Framebuffer Fill and Overwrite Controller

This block sits between the drawing side of a display subsystem and two framebuffer banks of equal size. One bank is shown while the other is drawn. The block has a single word-wide write port into the banks, and every write goes to the bank that is not being shown. Three kinds of traffic share that port: a register-driven fill engine, a CPU write path, and the display bank selector.

The fill engine is set up through a small register interface. A length register holds the word count minus one. A start register holds the first word address. Writing the data register launches the fill. The fill then writes one word per clock, and only the low row bits of the address advance, so a fill wraps inside its row. The CPU write path has two apertures. The lower aperture stores data exactly as given. The upper aperture treats zero bytes as transparent and leaves the memory bytes under them untouched.

A request to change the displayed bank takes effect at once only while vertical blank is active or the display mode is zero. Outside those conditions the request is held and applied on the next rising edge of vertical blank.

Top module: `fb_fill_ctrl`

## Requirements
- R1: After reset the displayed bank is 0, `cpu_busy` is low, no request is pending and `mem_we` is low.
- R2: A register write with `reg_sel`=2 while idle starts a fill. `cpu_busy` rises in the next cycle and stays high for exactly N+1 cycles, where N is the length register (written with `reg_sel`=0, low ROW_W bits of `reg_wdata`). During those cycles `mem_we` is high, every byte enable is set and `mem_wdata` equals the value written with `reg_sel`=2.
- R3: The first fill word goes to the start register (written with `reg_sel`=1, low ADDR_W bits). Each later word increments only the low ROW_W address bits, wrapping to zero, and the upper address bits do not change.
- R4: After a fill the start register holds the address that follows the last word written, with the same row wrap. A second write with `reg_sel`=2 and no new start value continues from that address.
- R5: Every memory write has `mem_bank` equal to the inverse of `disp_bank`.
- R6: A CPU write with `cpu_addr[ADDR_W]`=1 (the overwrite aperture) enables only those lanes that are requested in `cpu_be` and whose byte of `cpu_wdata` is nonzero. Lane i is `cpu_wdata[8i+7:8i]`. If no lane remains, no write occurs.
- R7: A CPU write with `cpu_addr[ADDR_W]`=0 is issued in the same cycle, with `cpu_be`, `cpu_wdata` and word address `cpu_addr[ADDR_W-1:0]` unchanged.
- R8: A register write with `reg_sel`=3 requests displayed bank `reg_wdata[0]`. The request takes effect in the next cycle if `vblank` is high or `disp_mode` is 0 in the cycle of the write.
- R9: Otherwise the request is held, and a later request replaces it. The held request is applied in the cycle that follows the first cycle in which `vblank` is high after having been low.
- R10: While `cpu_busy` is high, a CPU write produces no memory write of its own. Register writes with `reg_sel` 0, 1 or 2 are ignored. A bank request with `reg_sel`=3 is still accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | 0 length, 1 start, 2 data/launch, 3 bank request |
| reg_wdata | input | DATA_W | Register write value |
| cpu_we | input | 1 | CPU framebuffer write strobe; the CPU holds it while `cpu_busy` is high |
| cpu_addr | input | ADDR_W+1 | Word address; the top bit selects the overwrite aperture |
| cpu_wdata | input | DATA_W | CPU write data |
| cpu_be | input | DATA_W/8 | CPU byte-lane enables |
| vblank | input | 1 | Vertical blank status |
| disp_mode | input | 2 | Display mode; 0 allows an immediate bank change |
| cpu_busy | output | 1 | Fill in progress; CPU writes stall |
| mem_we | output | 1 | Memory write enable |
| mem_bank | output | 1 | Bank written (inverse of the displayed bank) |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_be | output | DATA_W/8 | Memory byte-lane enables |
| disp_bank | output | 1 | Currently displayed bank |

## Verification
The bench builds the block with ADDR_W=12 and ROW_W=4. With these values a full-row fill is only 16 words, so wrap-around, maximum length and fills that cross a row end all fit into short runs. They also fit among many swap requests, vertical blank edges and stalled CPU writes. The 16-bit data width gives two byte lanes, which covers the transparency cases: one zero lane, both lanes zero, and single-lane writes of zero.

// File: rtl/fb_fill_ctrl.sv
module fb_fill_ctrl #(
  parameter int ADDR_W = 16,
  parameter int ROW_W  = 8,
  parameter int DATA_W = 16,
  localparam int LANES = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [1:0]        reg_sel,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              cpu_we,
  input  logic [ADDR_W:0]   cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic [LANES-1:0]  cpu_be,
  input  logic              vblank,
  input  logic [1:0]        disp_mode,
  output logic              cpu_busy,
  output logic              mem_we,
  output logic              mem_bank,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic [LANES-1:0]  mem_be,
  output logic              disp_bank
);

  logic [ROW_W-1:0]  len_q, cnt_q;
  logic [ADDR_W-1:0] start_q;
  logic [DATA_W-1:0] data_q;
  logic              busy_q;
  logic              fs_q, pend_q, pval_q, vb_q;
  logic [LANES-1:0]  nz, cpu_lanes;

  wire sel_len   = reg_we && reg_sel == 2'd0;
  wire sel_start = reg_we && reg_sel == 2'd1;
  wire sel_data  = reg_we && reg_sel == 2'd2;
  wire sel_swap  = reg_we && reg_sel == 2'd3;
  wire swap_now  = vblank || disp_mode == 2'd0;
  wire vb_rise   = vblank && !vb_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      len_q   <= '0;
      cnt_q   <= '0;
      start_q <= '0;
      data_q  <= '0;
      busy_q  <= 1'b0;
    end else if (busy_q) begin
      start_q[ROW_W-1:0] <= start_q[ROW_W-1:0] + 1'b1;
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end else begin
      if (sel_len)   len_q   <= reg_wdata[ROW_W-1:0];
      if (sel_start) start_q <= reg_wdata[ADDR_W-1:0];
      if (sel_data) begin
        data_q <= reg_wdata;
        cnt_q  <= len_q;
        busy_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fs_q   <= 1'b0;
      pend_q <= 1'b0;
      pval_q <= 1'b0;
      vb_q   <= 1'b0;
    end else begin
      vb_q <= vblank;
      if (sel_swap) begin
        if (swap_now) begin
          fs_q   <= reg_wdata[0];
          pend_q <= 1'b0;
        end else begin
          pend_q <= 1'b1;
          pval_q <= reg_wdata[0];
        end
      end else if (vb_rise && pend_q) begin
        fs_q   <= pval_q;
        pend_q <= 1'b0;
      end
    end
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign nz[i] = |cpu_wdata[8*i +: 8];
  end

  assign cpu_lanes = cpu_addr[ADDR_W] ? (cpu_be & nz) : cpu_be;

  assign cpu_busy  = busy_q;
  assign disp_bank = fs_q;
  assign mem_bank  = ~fs_q;
  assign mem_we    = busy_q || (cpu_we && |cpu_lanes);
  assign mem_addr  = busy_q ? start_q : cpu_addr[ADDR_W-1:0];
  assign mem_wdata = busy_q ? data_q  : cpu_wdata;
  assign mem_be    = busy_q ? {LANES{1'b1}} : cpu_lanes;

endmodule

// File: rtl/fb_fill_ctrl_chk.sv
module fb_fill_ctrl_chk #(
  parameter int ADDR_W = 16,
  parameter int ROW_W  = 8,
  parameter int DATA_W = 16,
  localparam int LANES = DATA_W / 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_we,
  input logic [ADDR_W:0]   cpu_addr,
  input logic [DATA_W-1:0] cpu_wdata,
  input logic [LANES-1:0]  cpu_be,
  input logic              vblank,
  input logic [1:0]        disp_mode,
  input logic              cpu_busy,
  input logic              mem_we,
  input logic              mem_bank,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic [LANES-1:0]  mem_be,
  input logic              disp_bank
);

  p_fill_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_busy |-> (mem_we && mem_be == {LANES{1'b1}}));

  p_row_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_busy && $past(cpu_busy)) |->
      (mem_addr[ADDR_W-1:ROW_W] == $past(mem_addr[ADDR_W-1:ROW_W]) &&
       mem_addr[ROW_W-1:0] == ROW_W'($past(mem_addr[ROW_W-1:0]) + 1'b1)));

  p_draw_bank_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_bank != disp_bank);

  for (genvar i = 0; i < LANES; i++) begin : g_ovr
    p_ovr_lane_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && !cpu_busy && cpu_addr[ADDR_W] && mem_be[i]) |->
        (cpu_be[i] && cpu_wdata[8*i +: 8] != 8'h00));
  end

  p_plain_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_we && !cpu_busy && !cpu_addr[ADDR_W] && cpu_be != '0) |->
      (mem_we && mem_be == cpu_be && mem_wdata == cpu_wdata));

  p_swap_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_bank != $past(disp_bank)) |-> ($past(vblank) || $past(disp_mode) == 2'd0));

  p_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_busy && $past(cpu_busy)) |-> $stable(mem_wdata));

endmodule

bind fb_fill_ctrl fb_fill_ctrl_chk #(.ADDR_W(ADDR_W), .ROW_W(ROW_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
  .cpu_wdata(cpu_wdata), .cpu_be(cpu_be), .vblank(vblank), .disp_mode(disp_mode),
  .cpu_busy(cpu_busy), .mem_we(mem_we), .mem_bank(mem_bank), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .mem_be(mem_be), .disp_bank(disp_bank)
);

// File: tb/fb_fill_ctrl_bench.sv
module fb_fill_ctrl_bench;
  localparam int AW = 12;
  localparam int RW = 4;
  localparam int DW = 16;
  localparam int NL = DW / 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [1:0] reg_sel = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic cpu_we = 1'b0;
  logic [AW:0] cpu_addr = '0;
  logic [DW-1:0] cpu_wdata = '0;
  logic [NL-1:0] cpu_be = '0;
  logic vblank = 1'b0;
  logic [1:0] disp_mode = 2'd1;
  logic cpu_busy, mem_we, mem_bank, disp_bank;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic [NL-1:0] mem_be;

  always #2 clk = ~clk;

  fb_fill_ctrl #(.ADDR_W(AW), .ROW_W(RW), .DATA_W(DW)) u_fb_fill_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_be(cpu_be),
    .vblank(vblank), .disp_mode(disp_mode), .cpu_busy(cpu_busy), .mem_we(mem_we),
    .mem_bank(mem_bank), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_be(mem_be),
    .disp_bank(disp_bank)
  );

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  logic [RW-1:0] m_len, m_cnt;
  logic [AW-1:0] m_start;
  logic [DW-1:0] m_data;
  bit m_busy, m_fs, m_pend, m_pval, m_vbq;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_len = '0; m_cnt = '0; m_start = '0; m_data = '0;
      m_busy = 0; m_fs = 0; m_pend = 0; m_pval = 0; m_vbq = 0;
    end else begin
      if (reg_we && reg_sel == 2'd3) begin
        if (vblank || disp_mode == 2'd0) begin m_fs = reg_wdata[0]; m_pend = 0; end
        else begin m_pend = 1; m_pval = reg_wdata[0]; end
      end else if (vblank && !m_vbq && m_pend) begin
        m_fs = m_pval; m_pend = 0;
      end
      m_vbq = vblank;
      if (m_busy) begin
        m_start[RW-1:0] = m_start[RW-1:0] + 1'b1;
        if (m_cnt == 0) m_busy = 0;
        else m_cnt = m_cnt - 1'b1;
      end else if (reg_we) begin
        case (reg_sel)
          2'd0: m_len = reg_wdata[RW-1:0];
          2'd1: m_start = reg_wdata[AW-1:0];
          2'd2: begin m_data = reg_wdata; m_cnt = m_len; m_busy = 1; end
          default: ;
        endcase
      end
    end
  end

  int fill_words = 0;
  logic [AW-1:0] first_addr = '0;
  bit busy_d = 0;

  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic e_we;
      logic [NL-1:0] e_be;
      logic [AW-1:0] e_addr;
      logic [DW-1:0] e_data;
      string tag;
      if (m_busy) begin
        e_we = 1; e_be = '1; e_addr = m_start; e_data = m_data; tag = "R2/R3";
      end else begin
        e_be = cpu_we ? cpu_be : '0;
        if (cpu_addr[AW])
          for (int i = 0; i < NL; i++) if (cpu_wdata[8*i +: 8] == 8'h00) e_be[i] = 1'b0;
        e_we = |e_be; e_addr = cpu_addr[AW-1:0]; e_data = cpu_wdata;
        tag = cpu_addr[AW] ? "R6" : "R7";
      end
      check(cpu_busy == m_busy, "R2/R10 busy", cpu_busy, m_busy);
      check(disp_bank == m_fs, "R8/R9 bank", disp_bank, m_fs);
      check(mem_we == e_we, {tag, " we"}, mem_we, e_we);
      if (e_we) begin
        check(mem_be == e_be, {tag, " be"}, mem_be, e_be);
        check(mem_addr == e_addr, {tag, " addr"}, mem_addr, e_addr);
        check(mem_wdata == e_data, {tag, " data"}, mem_wdata, e_data);
        check(mem_bank == !m_fs, "R5 bank", mem_bank, !m_fs);
      end
      if (cpu_busy && !busy_d) begin first_addr = mem_addr; fill_words = 0; end
      if (cpu_busy && mem_we) fill_words++;
      busy_d = cpu_busy;
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic reg_wr(input logic [1:0] sel, input logic [DW-1:0] val);
    reg_we = 1; reg_sel = sel; reg_wdata = val;
    tick();
    reg_we = 0;
  endtask

  task automatic wait_idle();
    while (cpu_busy) tick();
  endtask

  task automatic fill(input int len, input int start, input logic [DW-1:0] val, input string tag);
    reg_wr(2'd0, DW'(len));
    reg_wr(2'd1, DW'(start));
    reg_wr(2'd2, val);
    wait_idle();
    check(fill_words == len + 1, {tag, " words"}, fill_words, len + 1);
    check(first_addr == AW'(start), {tag, " first"}, first_addr, start);
  endtask

  task automatic cpu_wr(input logic ovr, input int a, input logic [DW-1:0] d, input logic [NL-1:0] be);
    cpu_we = 1; cpu_addr = {ovr, AW'(a)}; cpu_wdata = d; cpu_be = be;
    @(negedge clk);
    #1;
    @(posedge clk); #1;
    cpu_we = 0;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      done = 1;
      fails++; tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst_n = 1;
    @(negedge clk);
    check(disp_bank == 0, "R1 bank", disp_bank, 0);
    check(cpu_busy == 0, "R1 busy", cpu_busy, 0);
    check(mem_we == 0, "R1 we", mem_we, 0);
    tick();

    fill(3, 'h0A5, 16'h1234, "R2");
    fill(5, 'h03E, 16'hA5A5, "R3");
    reg_wr(2'd2, 16'hBEEF);
    wait_idle();
    check(first_addr == AW'('h034), "R4 continue", first_addr, 'h034);
    fill(15, 'h7F0, 16'h0F0F, "R3 full row");
    reg_wr(2'd2, 16'h0001);
    wait_idle();
    check(first_addr == AW'('h7F0), "R4 wrap", first_addr, 'h7F0);

    cpu_wr(0, 'h123, 16'h0000, 2'b11);
    cpu_wr(1, 'h124, 16'h0012, 2'b11);
    cpu_wr(1, 'h125, 16'h0000, 2'b11);
    cpu_wr(1, 'h126, 16'h00FF, 2'b10);
    cpu_wr(1, 'h127, 16'h3400, 2'b10);

    reg_wr(2'd0, 16'd7);
    reg_wr(2'd2, 16'h5555);
    cpu_we = 1; cpu_addr = {1'b0, AW'('h200)}; cpu_wdata = 16'h9999; cpu_be = 2'b11;
    reg_wr(2'd1, 16'h0333);
    reg_wr(2'd0, 16'd2);
    reg_wr(2'd2, 16'h6666);
    wait_idle();
    @(negedge clk);
    check(mem_we && mem_wdata == 16'h9999, "R10 stalled write", mem_wdata, 16'h9999);
    tick();
    cpu_we = 0;

    disp_mode = 2'd1; vblank = 0;
    reg_wr(2'd3, 16'd1);
    repeat (3) tick();
    check(disp_bank == 0, "R9 held", disp_bank, 0);
    reg_wr(2'd3, 16'd0);
    reg_wr(2'd3, 16'd1);
    vblank = 1;
    tick();
    @(negedge clk);
    check(disp_bank == 1, "R9 applied", disp_bank, 1);
    reg_wr(2'd3, 16'd0);
    @(negedge clk);
    check(disp_bank == 0, "R8 vblank", disp_bank, 0);
    vblank = 0; disp_mode = 2'd0;
    reg_wr(2'd3, 16'd1);
    @(negedge clk);
    check(disp_bank == 1, "R8 mode0", disp_bank, 1);
    disp_mode = 2'd2;
    cpu_wr(0, 'h010, 16'hCAFE, 2'b01);

    for (int n = 0; n < 3000; n++) begin
      reg_we = ($urandom_range(0, 5) == 0);
      reg_sel = 2'($urandom);
      reg_wdata = DW'($urandom);
      cpu_we = $urandom_range(0, 1);
      cpu_addr = (AW + 1)'($urandom);
      cpu_wdata = ($urandom_range(0, 2) == 0) ? DW'($urandom & 32'h00FF) : DW'($urandom);
      cpu_be = NL'($urandom);
      if ($urandom_range(0, 9) == 0) vblank = ~vblank;
      if ($urandom_range(0, 19) == 0) disp_mode = 2'($urandom);
      tick();
    end
    reg_we = 0; cpu_we = 0;
    wait_idle();
    tick();

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule